// File: doc/BRIEF.md
# Interrupt Register Bank Save Controller

When the CPU accepts an interrupt, this block chooses where the interrupted context is saved. The context can go into a hardware register bank or onto the memory stack. If it goes to the bank, the block writes the register set into one bank entry, one word per cycle. Status and program counter always go to the stack, so every accepted interrupt gets a request for that save, whichever path the rest of the context takes.

Only external and on-chip peripheral interrupts may use the bank. Bank use can be switched off. When every entry is occupied, the context either falls back to the stack or raises a bank-overflow exception, depending on a configuration input. A 4-bit pointer counts the occupied entries. It rises after each completed save and falls on each restore acknowledge sent from the return path. The restore itself, the stack writes and the vector fetch are handled outside this block.

Top module: `irq_bank_save_ctrl`

## Requirements
- R1: Cause codes are: 0 external interrupt, 1 on-chip peripheral interrupt, 2 non-maskable interrupt, 3 user break, 4 address error, 5 RAM error, 6 register bank error, 7 instruction-caused exception. Only codes 0 and 1 may use the bank. Codes 2 to 7 never assert `bank_we_o`, never assert `stack_ctx_o` and never change `bank_ptr_o`.
- R2: Every accept taken while `busy_o` is low produces a one-cycle `sr_pc_save_o` pulse in the cycle after the accepting edge, for any cause and any path.
- R3: With `bank_en_i` low, an eligible accept produces a one-cycle `stack_ctx_o` pulse in the cycle after the accepting edge. It writes nothing to the bank and leaves `bank_ptr_o` unchanged.
- R4: With the bank enabled and `bank_ptr_o` below 15, an eligible accept asserts `bank_we_o` for 20 consecutive cycles, starting the cycle after the accepting edge. `bank_idx_o` runs from 0 to 19 and `bank_wdata_o` carries R0..R14 (indices 0-14, taken from `ctx_i` word i at bits 32i+31:32i), then GBR (15), MACH (16), MACL (17), PR (18), and finally the 10-bit vector offset zero-extended (19). The target entry is the `bank_ptr_o` value at the accept.
- R5: The words written are the `ctx_i` and `vec_off_i` values at the accepting edge. Later changes of those inputs do not alter `bank_wdata_o`.
- R6: `done_o` pulses for one cycle in the cycle after the word at index 19 is written. `bank_ptr_o` increases by one in that same cycle.
- R7: With the bank enabled, `bank_ptr_o` equal to 15 and `ovf_exc_en_i` low, an eligible accept produces a `stack_ctx_o` pulse. There is no bank write and no pointer change.
- R8: With the bank enabled, `bank_ptr_o` equal to 15 and `ovf_exc_en_i` high, an eligible accept produces an `ovf_exc_o` pulse. There is no `stack_ctx_o`, no bank write and no pointer change.
- R9: `restore_ack_i` while idle, with `bank_ptr_o` above 0 and no accept in the same cycle, lowers `bank_ptr_o` by one on the next cycle. It is ignored while busy, during an accept, or at pointer 0.
- R10: `accept_i` while `busy_o` is high is ignored and produces no pulse of any kind.
- R11: After reset, `bank_ptr_o` is 0 and every output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted this cycle |
| cause_i | input | 3 | Cause code of the accepted interrupt |
| vec_off_i | input | VEC_W (10) | Vector table offset of the accepted interrupt |
| bank_en_i | input | 1 | Register bank use enabled |
| ovf_exc_en_i | input | 1 | Bank-overflow exception enabled |
| ctx_i | input | N_REGS*DATA_W (608) | Register values R0..R14, GBR, MACH, MACL, PR |
| restore_ack_i | input | 1 | One bank entry released by the return path |
| busy_o | output | 1 | Bank save in progress |
| bank_we_o | output | 1 | Bank word write strobe |
| bank_ptr_o | output | PTR_W (4) | Occupied entry count, also the target entry |
| bank_idx_o | output | IDX_W (5) | Word index inside the entry |
| bank_wdata_o | output | DATA_W (32) | Word being written |
| done_o | output | 1 | Bank save finished |
| sr_pc_save_o | output | 1 | Request to push status and PC on the stack |
| stack_ctx_o | output | 1 | Context must be saved on the stack |
| ovf_exc_o | output | 1 | Bank-overflow exception request |

## Verification
The bench builds the block with its defaults: 32-bit words, 19 registers, a 10-bit vector field and 15 entries. With 15 entries the pointer reaches full after fifteen saves of twenty words each, so both full-bank outcomes can be reached in a few hundred cycles. Decrementing from there and saving again covers the step from full back to not full.

// File: rtl/ibs_pkg.sv
package ibs_pkg;

  typedef enum logic [2:0] {
    CAUSE_IRQ      = 3'd0,
    CAUSE_PERIPH   = 3'd1,
    CAUSE_NMI      = 3'd2,
    CAUSE_UBRK     = 3'd3,
    CAUSE_ADDR_ERR = 3'd4,
    CAUSE_RAM_ERR  = 3'd5,
    CAUSE_BANK_ERR = 3'd6,
    CAUSE_INSTR    = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_BANK,
    PATH_STACK,
    PATH_OVF
  } path_e;

endpackage

// File: rtl/ibs_path_decide.sv
module ibs_path_decide
  import ibs_pkg::*;
(
  input  logic [2:0] cause_i,
  input  logic       bank_en_i,
  input  logic       ovf_en_i,
  input  logic       full_i,
  output path_e      path_o
);

  cause_e cause;
  logic   eligible;

  assign cause    = cause_e'(cause_i);
  assign eligible = (cause == CAUSE_IRQ) || (cause == CAUSE_PERIPH);

  always_comb begin
    if (!eligible)       path_o = PATH_NONE;
    else if (!bank_en_i) path_o = PATH_STACK;
    else if (full_i)     path_o = ovf_en_i ? PATH_OVF : PATH_STACK;
    else                 path_o = PATH_BANK;
  end

endmodule

// File: rtl/ibs_bank_ptr.sv
module ibs_bank_ptr #(
  parameter int PTR_W = 4,
  parameter int DEPTH = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o,
  output logic             empty_o
);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (inc_i && !dec_i) ptr_q <= ptr_q + PTR_W'(1);
    else if (dec_i && !inc_i) ptr_q <= ptr_q - PTR_W'(1);
  end

  assign ptr_o   = ptr_q;
  assign full_o  = (ptr_q == PTR_W'(DEPTH));
  assign empty_o = (ptr_q == '0);

  AST_PTR_INC_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !full_o);  // R4
  AST_PTR_DEC_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !empty_o);  // R9

endmodule

// File: rtl/ibs_save_seq.sv
module ibs_save_seq #(
  parameter int DATA_W = 32,
  parameter int N_REGS = 19,
  parameter int VEC_W  = 10,
  parameter int IDX_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [N_REGS*DATA_W-1:0] ctx_i,
  input  logic [VEC_W-1:0]         vec_i,
  output logic                     busy_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [DATA_W-1:0]        wdata_o,
  output logic                     last_o,
  output logic                     done_o
);

  localparam int N_WORDS = N_REGS + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [DATA_W-1:0] words [N_WORDS];
  logic              busy_q, done_q;
  logic [IDX_W-1:0]  idx_q;

  // snapshot taken at start so the source may change during the save
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg_snap
    logic [DATA_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      w_q <= '0;
      else if (start_i) w_q <= ctx_i[g*DATA_W +: DATA_W];
    end
    assign words[g] = w_q;
  end

  logic [VEC_W-1:0] vec_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vec_q <= '0;
    else if (start_i) vec_q <= vec_i;
  end
  assign words[N_REGS] = {{(DATA_W-VEC_W){1'b0}}, vec_q};

  assign last_o = busy_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (last_o) busy_q <= 1'b0;
        else        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign wdata_o = words[idx_q];
  assign done_o  = done_q;

  AST_SEQ_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);  // R10

endmodule

// File: rtl/irq_bank_save_ctrl.sv
module irq_bank_save_ctrl
  import ibs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_REGS = 19,
  parameter int VEC_W  = 10,
  parameter int DEPTH  = 15,
  parameter int PTR_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(N_REGS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     accept_i,
  input  logic [2:0]               cause_i,
  input  logic [VEC_W-1:0]         vec_off_i,
  input  logic                     bank_en_i,
  input  logic                     ovf_exc_en_i,
  input  logic [N_REGS*DATA_W-1:0] ctx_i,
  input  logic                     restore_ack_i,
  output logic                     busy_o,
  output logic                     bank_we_o,
  output logic [PTR_W-1:0]         bank_ptr_o,
  output logic [IDX_W-1:0]         bank_idx_o,
  output logic [DATA_W-1:0]        bank_wdata_o,
  output logic                     done_o,
  output logic                     sr_pc_save_o,
  output logic                     stack_ctx_o,
  output logic                     ovf_exc_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REGS);

  path_e path;
  logic  busy, go, start, last, full, empty, dec;
  logic  sr_pc_q, stack_q, ovf_q;

  assign go    = accept_i && !busy;
  assign start = go && (path == PATH_BANK);
  assign dec   = restore_ack_i && !busy && !accept_i && !empty;

  ibs_path_decide u_decide (
    .cause_i  (cause_i),
    .bank_en_i(bank_en_i),
    .ovf_en_i (ovf_exc_en_i),
    .full_i   (full),
    .path_o   (path)
  );

  ibs_bank_ptr #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (last),
    .dec_i  (dec),
    .ptr_o  (bank_ptr_o),
    .full_o (full),
    .empty_o(empty)
  );

  ibs_save_seq #(.DATA_W(DATA_W), .N_REGS(N_REGS), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .ctx_i  (ctx_i),
    .vec_i  (vec_off_i),
    .busy_o (busy),
    .idx_o  (bank_idx_o),
    .wdata_o(bank_wdata_o),
    .last_o (last),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_pc_q <= 1'b0;
      stack_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      sr_pc_q <= go;
      stack_q <= go && (path == PATH_STACK);
      ovf_q   <= go && (path == PATH_OVF);
    end
  end

  assign busy_o       = busy;
  assign bank_we_o    = busy;
  assign sr_pc_save_o = sr_pc_q;
  assign stack_ctx_o  = stack_q;
  assign ovf_exc_o    = ovf_q;

  AST_INELIGIBLE_NO_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !busy_o && cause_i > 3'd1) |=> (!bank_we_o && !stack_ctx_o));  // R1
  AST_SR_PC_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !busy_o) |=> sr_pc_save_o);  // R2
  AST_STACK_PTR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_ctx_o |-> ($stable(bank_ptr_o) && !bank_we_o));  // R3
  AST_WORDS_CONTIGUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_o && bank_idx_o != LAST_IDX) |=>
      (bank_we_o && bank_idx_o == $past(bank_idx_o) + IDX_W'(1)));  // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_o && bank_idx_o == LAST_IDX) |=>
      (done_o && bank_ptr_o == $past(bank_ptr_o) + PTR_W'(1)));  // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stack_ctx_o, ovf_exc_o, done_o}));  // R7
  AST_OVF_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_exc_o |-> (bank_ptr_o == PTR_W'(DEPTH) && !bank_we_o));  // R8
  AST_RESTORE_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && restore_ack_i && bank_idx_o != LAST_IDX) |=> $stable(bank_ptr_o));  // R9
  AST_ACCEPT_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && busy_o) |=> (!sr_pc_save_o && !ovf_exc_o));  // R10

endmodule

// File: tb/irq_bank_save_ctrl_tb.sv
`timescale 1ns/1ps
module irq_bank_save_ctrl_tb;

  localparam int DW = 32;
  localparam int NR = 19;
  localparam int NW = NR + 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           accept = 1'b0;
  logic [2:0]     cause = 3'd0;
  logic [9:0]     vec = 10'd0;
  logic           bank_en = 1'b0;
  logic           ovf_en = 1'b0;
  logic [NR*DW-1:0] ctx = '0;
  logic           restore = 1'b0;
  logic           busy, we, done, srpc, stk, ovf;
  logic [3:0]     ptr;
  logic [4:0]     idx;
  logic [31:0]    wdata;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  irq_bank_save_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept), .cause_i(cause),
    .vec_off_i(vec), .bank_en_i(bank_en), .ovf_exc_en_i(ovf_en), .ctx_i(ctx),
    .restore_ack_i(restore), .busy_o(busy), .bank_we_o(we), .bank_ptr_o(ptr),
    .bank_idx_o(idx), .bank_wdata_o(wdata), .done_o(done), .sr_pc_save_o(srpc),
    .stack_ctx_o(stk), .ovf_exc_o(ovf)
  );

  // behavioural reference
  logic        m_busy, m_done, m_srpc, m_stk, m_ovf;
  int          m_cnt, m_ptr;
  logic [31:0] m_words [NW];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_srpc <= 0; m_stk <= 0; m_ovf <= 0;
      m_cnt <= 0; m_ptr <= 0;
    end else begin
      m_done <= 0; m_srpc <= 0; m_stk <= 0; m_ovf <= 0;
      if (m_busy) begin
        if (m_cnt == NW - 1) begin
          m_busy <= 0; m_done <= 1; m_ptr <= m_ptr + 1;
        end else m_cnt <= m_cnt + 1;
      end else if (accept) begin
        m_srpc <= 1;
        if (cause <= 3'd1) begin
          if (!bank_en) m_stk <= 1;
          else if (m_ptr == 15) begin
            if (ovf_en) m_ovf <= 1; else m_stk <= 1;
          end else begin
            m_busy <= 1; m_cnt <= 0;
            for (int i = 0; i < NR; i++) m_words[i] <= ctx[i*DW +: DW];
            m_words[NR] <= {22'd0, vec};
          end
        end
      end else if (restore && m_ptr > 0) m_ptr <= m_ptr - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R4 bank_we", {31'd0, we}, {31'd0, m_busy});
    chk("R10 busy", {31'd0, busy}, {31'd0, m_busy});
    if (m_busy) begin
      chk("R4 index", {27'd0, idx}, m_cnt);
      chk("R5 wdata", wdata, m_words[m_cnt]);
    end
    chk("R9 pointer", {28'd0, ptr}, m_ptr);
    chk("R6 done", {31'd0, done}, {31'd0, m_done});
    chk("R2 sr_pc", {31'd0, srpc}, {31'd0, m_srpc});
    chk("R7 stack", {31'd0, stk}, {31'd0, m_stk});
    chk("R8 ovf", {31'd0, ovf}, {31'd0, m_ovf});
  end

  function automatic logic [NR*DW-1:0] pattern(input int seed);
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++)
      v[i*DW +: DW] = (32'(seed) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9);
    return v;
  endfunction

  task automatic fire(input logic [2:0] c, input logic [9:0] v, input int seed);
    @(posedge clk); #1;
    accept = 1; cause = c; vec = v; ctx = pattern(seed);
    @(posedge clk); #1;
    accept = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_restore();
    @(posedge clk); #1; restore = 1;
    @(posedge clk); #1; restore = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #9;
    // R11 reset state
    chk("R11 reset ptr", {28'd0, ptr}, 0);
    chk("R11 reset strobes", {26'd0, busy, we, done, srpc, stk, ovf}, 0);
    rst_n = 1;
    idle(2);

    // R3: bank disabled, eligible cause
    bank_en = 0;
    fire(3'd0, 10'h12, 1); idle(3);
    fire(3'd1, 10'h34, 2); idle(3);
    chk("R3 ptr unchanged", {28'd0, ptr}, 0);

    // R9: restore at pointer 0 ignored
    pulse_restore(); idle(2);
    chk("R9 restore at zero", {28'd0, ptr}, 0);

    // R1: ineligible causes with bank enabled
    bank_en = 1;
    for (int c = 2; c < 8; c++) begin
      fire(3'(c), 10'(c), 10 + c); idle(3);
    end
    chk("R1 ptr after ineligible", {28'd0, ptr}, 0);

    // R4 R5 R10 R9: first save with disturbances during busy
    fire(3'd0, 10'h3FF, 100);
    idle(3);
    ctx = pattern(555); vec = 10'h001;           // R5
    accept = 1; cause = 3'd0; idle(1); accept = 0; // R10
    restore = 1; idle(1); restore = 0;          // R9 busy
    idle(25);
    chk("R6 ptr after save", {28'd0, ptr}, 1);

    // fill to full with alternating causes
    for (int k = 0; k < 14; k++) begin
      fire(3'(k % 2), 10'(k * 37), 200 + k);
      idle(24);
    end
    chk("R4 ptr full", {28'd0, ptr}, 15);

    // R7 full, overflow disabled
    ovf_en = 0;
    fire(3'd1, 10'h55, 300); idle(3);
    chk("R7 ptr stays full", {28'd0, ptr}, 15);

    // R8 full, overflow enabled
    ovf_en = 1;
    fire(3'd0, 10'h66, 301); idle(3);
    chk("R8 ptr stays full", {28'd0, ptr}, 15);

    // R9 restore with concurrent accept is ignored, then plain restores
    @(posedge clk); #1; restore = 1; accept = 1; cause = 3'd2;
    @(posedge clk); #1; restore = 0; accept = 0;
    idle(2);
    chk("R9 restore during accept", {28'd0, ptr}, 15);
    pulse_restore(); pulse_restore(); idle(2);
    chk("R9 ptr after restores", {28'd0, ptr}, 13);

    // save again after leaving full
    fire(3'd1, 10'h2AA, 400); idle(25);
    chk("R6 ptr after resave", {28'd0, ptr}, 14);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule